// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

When a processor takes an exception, this block saves the interrupted context to memory. A one-cycle start request supplies the exception number, the current mode, which stack pointer is active, both stack pointer values, the current status word and seven general register values. The block captures all of these in one cycle. It then pushes an eight-word frame downward from the selected stack pointer, one 32-bit write at a time, over a request/acknowledge memory port.

When the last write is acknowledged, the block pulses done. In the same cycle it presents the new stack pointer value for the selected pointer, the return code for the link register, and the status word that was saved. If the stack pointer was only 4-byte aligned, one pad word is inserted so that the frame base is 8-byte aligned. The saved status word records that this pad was used.

The controller has three states. ST_IDLE waits for start; start moves it to ST_PUSH. ST_PUSH holds the write request until it is acknowledged. An acknowledge of beats 0 to 6 stays in ST_PUSH with the next beat. The acknowledge of beat 7 moves to ST_FINISH. ST_FINISH lasts one cycle and always returns to ST_IDLE.

Top module: `exc_stack_seq`

## Requirements
- R1: After reset the block is in ST_IDLE: mem_req_o, done_o, sp_wr_o and stk_err_o are all 0.
- R2: A start_i sampled in ST_IDLE captures all inputs. From the next cycle, eight writes are issued in this order: saved status, return address, link register, R12, R3, R2, R1, R0. They go to addresses base+28, base+24, and so on down to base+0, so the address drops by 4 per beat and R0 ends at the lowest address.
- R3: The stack pointer used is psp_i when psp_sel_i is 1, and msp_i otherwise. Both are assumed word aligned. If bit 2 of that pointer is 1, then base = SP-36 and bit 9 of the saved status is 1. If bit 2 is 0, then base = SP-32 and bit 9 is 0. In both cases base is 8-byte aligned.
- R4: The saved status word is built as follows: bits 31:27 and bit 24 are copied from psr_i, bits 8:0 hold exc_num_i, bit 9 is the realign bit, and all other bits are 0.
- R5: The return code is built as follows: bits 31:4 are 1, bit 3 equals thread_i (1 means thread mode), bit 2 equals psp_sel_i (1 means process stack), and bits 1:0 are 0. Bit 4 = 1 marks a standard frame.
- R6: sp_wr_o pulses together with done_o. At that point sp_new_o equals base and sp_sel_o equals the captured psp_sel_i.
- R7: mem_req_o stays high with stable address and data until mem_ack_i is seen. Each acknowledge completes exactly one write.
- R8: done_o is high for exactly one cycle, the cycle after the eighth acknowledge. During that cycle mem_req_o is 0.
- R9: If mem_err_i is 1 with any acknowledge, stk_err_o goes to 1 from the next cycle. The remaining writes still go out. The flag holds until the next accepted start, which clears it.
- R10: A start_i that arrives while a sequence is in progress is ignored. It does not change the writes, sp_new_o, exc_return_o or saved_psr_o of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| exc_num_i | input | 9 | Exception number to record |
| thread_i | input | 1 | 1 = interrupted code was in thread mode |
| psp_sel_i | input | 1 | 1 = process stack pointer active |
| msp_i | input | 32 | Main stack pointer value |
| psp_i | input | 32 | Process stack pointer value |
| psr_i | input | 32 | Current status word (flags) |
| ret_addr_i | input | 32 | Return address to save |
| lr_i | input | 32 | Link register to save |
| r12_i | input | 32 | R12 to save |
| r3_i | input | 32 | R3 to save |
| r2_i | input | 32 | R2 to save |
| r1_i | input | 32 | R1 to save |
| r0_i | input | 32 | R0 to save |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Write acknowledge |
| mem_err_i | input | 1 | Bus error qualifying mem_ack_i |
| done_o | output | 1 | Sequence complete pulse |
| stk_err_o | output | 1 | Stacking error flag |
| sp_wr_o | output | 1 | Stack pointer write-back strobe |
| sp_sel_o | output | 1 | Which pointer to update (1 = process) |
| sp_new_o | output | 32 | New stack pointer value |
| exc_return_o | output | 32 | Return code for the link register |
| saved_psr_o | output | 32 | Status word that was pushed |

## Verification
The assertions assume three things about the inputs. First, the selected stack pointer is word aligned. Second, mem_ack_i is only driven while mem_req_o is high. Third, mem_err_i only has meaning alongside mem_ack_i. Under these assumptions, the frame base alignment and the 4-byte address step between beats must hold. The bench memory model acknowledges only pending requests, with a delay of zero to two cycles. Its stack pointer values always have bits 1:0 clear and cover both values of bit 2. Error injection is restricted to acknowledged beats.

// File: rtl/exc_stack_pkg.sv
package exc_stack_pkg;
    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 8;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int EXC_W       = 9;
    localparam int REALIGN_BIT = 9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PUSH   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/exc_stack_ctrl.sv
module exc_stack_ctrl
    import exc_stack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ack_i,
    input  logic             err_i,
    output logic             load_o,
    output logic             req_o,
    output logic             done_o,
    output logic             err_o,
    output logic [IDX_W-1:0] beat_o
);
    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(FRAME_WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] beat_q;
    logic             err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                beat_q <= '0;
                err_q  <= 1'b0;
            end else if (req_o && ack_i) begin
                beat_q <= beat_q + 1'b1;
                if (err_i) err_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_PUSH;
            ST_PUSH:   if (ack_i && beat_q == LAST_BEAT) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        req_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_PUSH:   req_o  = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    assign err_o  = err_q;
    assign beat_o = beat_q;
endmodule

// File: rtl/exc_stack_frame.sv
module exc_stack_frame
    import exc_stack_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  beat_i,
    input  logic [EXC_W-1:0]  exc_num_i,
    input  logic              thread_i,
    input  logic              psp_sel_i,
    input  logic [ADDR_W-1:0] msp_i,
    input  logic [ADDR_W-1:0] psp_i,
    input  logic [WORD_W-1:0] psr_i,
    input  logic [WORD_W-1:0] ret_addr_i,
    input  logic [WORD_W-1:0] lr_i,
    input  logic [WORD_W-1:0] r12_i,
    input  logic [WORD_W-1:0] r3_i,
    input  logic [WORD_W-1:0] r2_i,
    input  logic [WORD_W-1:0] r1_i,
    input  logic [WORD_W-1:0] r0_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [WORD_W-1:0] saved_psr_o,
    output logic              thread_o,
    output logic              psp_sel_o
);
    localparam int               FRAME_BYTES = FRAME_WORDS * 4;
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(FRAME_WORDS - 1);
    localparam logic [WORD_W-1:0] KEEP_MASK  = 32'hF900_0000;

    logic [WORD_W-1:0] word_q [FRAME_WORDS];
    logic [WORD_W-1:0] word_d [FRAME_WORDS];
    logic [ADDR_W-1:0] base_q;
    logic              thread_q, psp_q;

    logic [ADDR_W-1:0] sp_cur;
    logic              pad;
    logic [WORD_W-1:0] psr_new;

    always_comb begin
        sp_cur  = psp_sel_i ? psp_i : msp_i;
        pad     = sp_cur[2];
        psr_new = psr_i & KEEP_MASK;
        psr_new[REALIGN_BIT] = pad;
        psr_new[EXC_W-1:0]   = exc_num_i;
        word_d[0] = psr_new;
        word_d[1] = ret_addr_i;
        word_d[2] = lr_i;
        word_d[3] = r12_i;
        word_d[4] = r3_i;
        word_d[5] = r2_i;
        word_d[6] = r1_i;
        word_d[7] = r0_i;
    end

    for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word_q[g] <= '0;
            else if (load_i) word_q[g] <= word_d[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            thread_q <= 1'b0;
            psp_q    <= 1'b0;
        end else if (load_i) begin
            base_q   <= sp_cur - ADDR_W'(FRAME_BYTES) - (pad ? ADDR_W'(4) : '0);
            thread_q <= thread_i;
            psp_q    <= psp_sel_i;
        end
    end

    assign addr_o      = base_q + {{(ADDR_W-IDX_W-2){1'b0}}, LAST_IDX - beat_i, 2'b00};
    assign wdata_o     = word_q[beat_i];
    assign base_o      = base_q;
    assign saved_psr_o = word_q[0];
    assign thread_o    = thread_q;
    assign psp_sel_o   = psp_q;
endmodule

// File: rtl/exc_stack_retcode.sv
module exc_stack_retcode
    import exc_stack_pkg::*;
(
    input  logic              thread_i,
    input  logic              psp_sel_i,
    output logic [WORD_W-1:0] code_o
);
    always_comb begin
        code_o      = '1;
        code_o[3]   = thread_i;
        code_o[2]   = psp_sel_i;
        code_o[1:0] = 2'b00;
    end
endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq
    import exc_stack_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [EXC_W-1:0]  exc_num_i,
    input  logic              thread_i,
    input  logic              psp_sel_i,
    input  logic [ADDR_W-1:0] msp_i,
    input  logic [ADDR_W-1:0] psp_i,
    input  logic [WORD_W-1:0] psr_i,
    input  logic [WORD_W-1:0] ret_addr_i,
    input  logic [WORD_W-1:0] lr_i,
    input  logic [WORD_W-1:0] r12_i,
    input  logic [WORD_W-1:0] r3_i,
    input  logic [WORD_W-1:0] r2_i,
    input  logic [WORD_W-1:0] r1_i,
    input  logic [WORD_W-1:0] r0_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    output logic              done_o,
    output logic              stk_err_o,
    output logic              sp_wr_o,
    output logic              sp_sel_o,
    output logic [ADDR_W-1:0] sp_new_o,
    output logic [WORD_W-1:0] exc_return_o,
    output logic [WORD_W-1:0] saved_psr_o
);
    logic             load;
    logic [IDX_W-1:0] beat;
    logic             thread_cap;

    exc_stack_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .ack_i  (mem_ack_i),
        .err_i  (mem_err_i),
        .load_o (load),
        .req_o  (mem_req_o),
        .done_o (done_o),
        .err_o  (stk_err_o),
        .beat_o (beat)
    );

    exc_stack_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .beat_i     (beat),
        .exc_num_i  (exc_num_i),
        .thread_i   (thread_i),
        .psp_sel_i  (psp_sel_i),
        .msp_i      (msp_i),
        .psp_i      (psp_i),
        .psr_i      (psr_i),
        .ret_addr_i (ret_addr_i),
        .lr_i       (lr_i),
        .r12_i      (r12_i),
        .r3_i       (r3_i),
        .r2_i       (r2_i),
        .r1_i       (r1_i),
        .r0_i       (r0_i),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o),
        .base_o     (sp_new_o),
        .saved_psr_o(saved_psr_o),
        .thread_o   (thread_cap),
        .psp_sel_o  (sp_sel_o)
    );

    exc_stack_retcode u_ret (
        .thread_i (thread_cap),
        .psp_sel_i(sp_sel_o),
        .code_o   (exc_return_o)
    );

    assign sp_wr_o = done_o;
endmodule

// File: rtl/exc_stack_seq_chk.sv
module exc_stack_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic              mem_ack_i,
    input logic              mem_err_i,
    input logic              done_o,
    input logic              stk_err_o,
    input logic              sp_wr_o,
    input logic [ADDR_W-1:0] sp_new_o,
    input logic [31:0]       exc_return_o
);
    // R7: a pending write holds address and data until acknowledged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

    // R2: consecutive beats step down by one word
    p_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req_o && mem_ack_i) && mem_req_o |-> mem_addr_o == $past(mem_addr_o) - ADDR_W'(4));

    // R8: done is a single-cycle pulse with no request alongside
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o ##1 !done_o);

    // R6: stack pointer strobe coincides with done
    p_sp_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_o == done_o);

    // R3: new stack pointer is 8-byte aligned
    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sp_new_o[2:0] == 3'b000);

    // R5: return code prefix and low bits
    p_retcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> exc_return_o[31:4] == 28'hFFFFFFF && exc_return_o[1:0] == 2'b00);

    // R9: an errored acknowledge raises the flag
    p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i && mem_err_i |=> stk_err_o);
endmodule

bind exc_stack_seq exc_stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/exc_stack_seq_test.sv
`timescale 1ns/1ps
module exc_stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [8:0]  exc_num_i = '0;
    logic        thread_i = 1'b0, psp_sel_i = 1'b0;
    logic [31:0] msp_i = '0, psp_i = '0, psr_i = '0;
    logic [31:0] ret_addr_i = '0, lr_i = '0, r12_i = '0;
    logic [31:0] r3_i = '0, r2_i = '0, r1_i = '0, r0_i = '0;
    logic        mem_req_o, mem_ack_i = 1'b0, mem_err_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        done_o, stk_err_o, sp_wr_o, sp_sel_o;
    logic [31:0] sp_new_o, exc_return_o, saved_psr_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    exc_stack_seq uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_seq(input int run, input logic [8:0] excn, input bit thr, input bit psp,
                           input bit pad, input int errbeat, input bit busy_start);
        logic [31:0] sp, other, base, psr, exp_psr, exp_ret;
        logic [31:0] exp_w [8];
        logic [31:0] got_a [8];
        logic [31:0] got_d [8];
        int beat, wait_c, cyc_after_last;
        bit any_err, seen_done;
        sp    = 32'h2000_1000 + 32'(run) * 64 + (pad ? 32'd4 : 32'd0);
        other = 32'h3000_0000 + 32'(run) * 128;
        psr   = 32'hA5A5_5A5A ^ (32'(run) * 32'h0101_0101);
        base  = sp - 32'd32 - (pad ? 32'd4 : 32'd0);
        exp_psr = (psr & 32'hF900_0000) | (32'(pad) << 9) | 32'(excn);
        exp_ret = 32'hFFFF_FFF0 | (32'(thr) << 3) | (32'(psp) << 2);
        exp_w[0] = exp_psr;
        for (int i = 1; i < 8; i++) exp_w[i] = 32'h1000_0000 * 32'(i) + 32'(run);
        @(negedge clk);
        exc_num_i = excn; thread_i = thr; psp_sel_i = psp;
        msp_i = psp ? other : sp; psp_i = psp ? sp : other; psr_i = psr;
        ret_addr_i = exp_w[1]; lr_i = exp_w[2]; r12_i = exp_w[3]; r3_i = exp_w[4];
        r2_i = exp_w[5]; r1_i = exp_w[6]; r0_i = exp_w[7];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R9: accepted start clears flag
        chk(stk_err_o == 1'b0, "R9 clear on start", 32'(stk_err_o), 32'd0);
        beat = 0; wait_c = run % 3; any_err = 0; seen_done = 0; cyc_after_last = -1;
        for (int c = 0; c < 60 && !seen_done; c++) begin
            if (cyc_after_last >= 0) cyc_after_last++;
            if (done_o) begin
                seen_done = 1;
                chk(cyc_after_last == 1, "R8 done timing", 32'(cyc_after_last), 32'd1);
                chk(beat == 8, "R7 write count", 32'(beat), 32'd8);
                chk(mem_req_o == 1'b0, "R8 no req with done", 32'(mem_req_o), 32'd0);
                for (int i = 0; i < 8; i++) begin
                    chk(got_a[i] == base + 32'(28 - 4 * i), "R2 address", got_a[i], base + 32'(28 - 4 * i));
                    chk(got_d[i] == exp_w[i], "R2 data order", got_d[i], exp_w[i]);
                end
                chk(got_d[0] == exp_psr, "R4 saved status", got_d[0], exp_psr);
                chk(saved_psr_o[9] == pad, "R3 realign bit", 32'(saved_psr_o[9]), 32'(pad));
                chk(saved_psr_o == exp_psr, "R4 saved_psr_o", saved_psr_o, exp_psr);
                chk(sp_new_o == base, "R3 base", sp_new_o, base);
                chk(sp_wr_o == 1'b1 && sp_sel_o == psp, "R6 sp write", {30'd0, sp_wr_o, sp_sel_o}, {30'd0, 1'b1, psp});
                chk(exc_return_o == exp_ret, "R5 return code", exc_return_o, exp_ret);
                chk(stk_err_o == any_err, "R9 error flag", 32'(stk_err_o), 32'(any_err));
                mem_ack_i = 1'b0; mem_err_i = 1'b0;
            end else if (mem_req_o) begin
                if (busy_start && beat == 3) begin
                    start_i = 1'b1; exc_num_i = ~excn; psp_sel_i = ~psp;
                    r0_i = 32'hDEAD_BEEF; psr_i = ~psr;
                end else begin
                    start_i = 1'b0;
                end
                if (wait_c == 0 && beat < 8) begin
                    got_a[beat] = mem_addr_o; got_d[beat] = mem_wdata_o;
                    mem_ack_i = 1'b1;
                    mem_err_i = (beat == errbeat);
                    if (beat == errbeat) any_err = 1;
                    if (beat == 7) cyc_after_last = 0;
                    beat++;
                    wait_c = (beat + run) % 3;
                end else begin
                    mem_ack_i = 1'b0; mem_err_i = 1'b0;
                    if (wait_c > 0) wait_c--;
                end
            end else begin
                mem_ack_i = 1'b0; mem_err_i = 1'b0; start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(seen_done, "R8 done seen", 32'(seen_done), 32'd1);
        chk(done_o == 1'b0 && sp_wr_o == 1'b0, "R8 done one cycle", 32'(done_o), 32'd0);
        @(negedge clk);
        chk(stk_err_o == any_err, "R9 flag held", 32'(stk_err_o), 32'(any_err));
        if (busy_start)
            chk(exc_return_o == exp_ret && sp_new_o == base, "R10 busy start ignored", sp_new_o, base);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [8:0] excs [5];
        int run;
        excs[0] = 9'd0; excs[1] = 9'd3; excs[2] = 9'd11; excs[3] = 9'd255; excs[4] = 9'd511;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_req_o && !done_o && !sp_wr_o && !stk_err_o, "R1 reset idle",
            {28'd0, mem_req_o, done_o, sp_wr_o, stk_err_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !done_o, "R1 idle without start", {30'd0, mem_req_o, done_o}, 32'd0);
        run = 0;
        for (int e = 0; e < 5; e++)
            for (int t = 0; t < 2; t++)
                for (int p = 0; p < 2; p++)
                    for (int a = 0; a < 2; a++)
                        for (int k = 0; k < 3; k++) begin
                            int eb;
                            eb = (k == 0) ? -1 : (k == 1) ? (run % 8) : 7;
                            run_seq(run, excs[e], t[0], p[0], a[0], eb, (run % 4) == 1);
                            run++;
                        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule